// File: doc/BRIEF.md
# Serial Sampling-Converter Output Emulator

This block stands in for the digital side of a three-wire serial sampling converter. A parallel port supplies a straight-binary sample word, where 0 means zero differential input and all ones means full scale. An active-low chip select and an externally driven data clock control the serial output, just as a host sees them on a real converter. The serial line has a separate output-enable flag that marks when the pin would leave its high-impedance state. No analog behaviour is modelled.

Chip select and data clock come from outside the system clock domain. Each passes through its own synchronizer chain, and the emulator acts on the synchronized data-clock falling edges. A falling chip select latches the sample word. The emulator then waits through one data-clock falling edge for sampling, enables the line with a low null bit, and sends the word most significant bit first. If the host keeps clocking, the word goes out again starting from bit 1, so bit 0 is not repeated, and after that the line sends zeros. Raising chip select ends the frame at once.

Top module: `adc_serial_emu`

## Requirements
- R1: While the synchronized chip select is high, `sdo_oe` and `sdo` are both 0. A frame that completes and then has chip select raised returns to this idle state.
- R2: A frame begins when chip select falls. The first data-clock falling edge after that leaves `sdo_oe` at 0. The second falling edge sets `sdo_oe` to 1 and drives `sdo` to 0, which is the null bit.
- R3: Falling edges 3 through 14 of the frame present bits 11 down to 0 of the latched word on `sdo`, in that order.
- R4: Outputs change only in response to a synchronized data-clock falling edge or to chip select. Each new value appears within SYNC_STAGES+2 system-clock cycles after the data-clock falling edge, and the outputs hold steady while the data clock is high.
- R5: Falling edges 15 through 25 present bits 1 up to 11 of the word, in ascending order. Bit 0 is not sent again.
- R6: From falling edge 26 onward, `sdo` is 0 for as long as chip select stays low, and `sdo_oe` stays 1.
- R7: `sample_word` is captured at the chip-select falling edge. Any change to it later in the frame has no effect on `sdo`.
- R8: If chip select rises partway through a frame, the frame is aborted and the outputs return to idle. The next frame starts again from the sampling edge.
- R9: The extreme codes come through unaltered, with 0x000 sent as all zeros and 0xFFF sent as all ones in the data positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial controls |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select; a falling edge starts a frame |
| dclk | input | 1 | Externally supplied data clock |
| sample_word | input | DATA_W | Straight-binary sample to be sent |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | 1 when the serial line is driven, 0 for high impedance |

## Verification
Several properties are checked on every system-clock cycle. The line is idle whenever chip select is high. Outputs hold between data-clock falling edges. The line is only ever enabled on the second edge, and always with a low null bit. The latched word changes only at a frame start. The saturated tail carries zeros. Only the bench scenarios can confirm the actual bit order: the MSB-first pass, the ascending repeat without bit 0, and the zero tail. The same applies to the effect of changing the parallel word during a frame, the restart after an aborted frame, and the all-zero and all-one codes. The bench checks these against a queue of expected line states that it builds for each frame.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

  parameter int WORD_W = 12;

  typedef enum logic [2:0] {
    PH_SAMPLE,
    PH_NULL,
    PH_MSB,
    PH_LSB,
    PH_ZERO
  } phase_e;

  // Falling-edge index (1-based) within a frame -> phase of the line.
  function automatic phase_e phase_of(int idx, int w);
    if (idx < 2)            return PH_SAMPLE;
    else if (idx == 2)      return PH_NULL;
    else if (idx <= w + 2)  return PH_MSB;
    else if (idx <= 2*w + 1) return PH_LSB;
    else                    return PH_ZERO;
  endfunction

  // Bit position of the word shown at a given data edge.
  function automatic int bit_pos(int idx, int w);
    if (phase_of(idx, w) == PH_MSB) return w + 2 - idx;
    else if (phase_of(idx, w) == PH_LSB) return idx - (w + 2);
    else return 0;
  endfunction

endpackage

// File: rtl/adc_ser_sync.sv
module adc_ser_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              last;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= IDLE;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{IDLE}};
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= IDLE;
    else        last <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign fall  = last & ~chain[STAGES-1];

endmodule

// File: rtl/adc_ser_framer.sv
module adc_ser_framer
  import adc_ser_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_high,
  input  logic              cs_fall,
  input  logic              clk_fall,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] word_q,
  output logic [CNT_W-1:0]  edge_cnt,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(2*DATA_W + 2);

  function automatic logic pick(logic [DATA_W-1:0] w, int idx);
    phase_e            ph;
    logic [DATA_W-1:0] sh;
    ph = phase_of(idx, DATA_W);
    sh = w >> bit_pos(idx, DATA_W);
    if (ph == PH_MSB || ph == PH_LSB) return sh[0];
    else return 1'b0;
  endfunction

  logic [CNT_W-1:0] cnt_nxt;
  assign cnt_nxt = (edge_cnt == CNT_MAX) ? edge_cnt : edge_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      edge_cnt <= '0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else if (cs_high) begin
      edge_cnt <= '0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else if (cs_fall) begin
      word_q   <= data_in;
      edge_cnt <= '0;
    end else if (clk_fall) begin
      edge_cnt <= cnt_nxt;
      sdo_oe   <= (phase_of(32'(cnt_nxt), DATA_W) != PH_SAMPLE);
      sdo      <= pick(word_q, 32'(cnt_nxt));
    end
  end

endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu #(
  parameter int DATA_W      = adc_ser_pkg::WORD_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              dclk,
  input  logic [DATA_W-1:0] sample_word,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int CNT_W = $clog2(2*DATA_W + 3);

  logic              cs_lvl;
  logic              cs_fall;
  logic              dclk_lvl;
  logic              dclk_fall;
  logic [DATA_W-1:0] word_q;
  logic [CNT_W-1:0]  edge_cnt;

  adc_ser_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .level(cs_lvl), .fall(cs_fall)
  );

  adc_ser_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_dclk_sync (
    .clk(clk), .rst_n(rst_n), .din(dclk), .level(dclk_lvl), .fall(dclk_fall)
  );

  adc_ser_framer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst_n(rst_n),
    .cs_high(cs_lvl), .cs_fall(cs_fall), .clk_fall(dclk_fall),
    .data_in(sample_word), .word_q(word_q), .edge_cnt(edge_cnt),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  logic unused_lvl;
  assign unused_lvl = dclk_lvl;

endmodule

// File: rtl/adc_serial_emu_chk.sv
module adc_serial_emu_chk #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              cs_fall,
  input logic              clk_fall,
  input logic [DATA_W-1:0] word_q,
  input logic [CNT_W-1:0]  edge_cnt,
  input logic              sdo,
  input logic              sdo_oe
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(2*DATA_W + 2);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!sdo_oe && !sdo));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !clk_fall) |=> ($stable(sdo_oe) && $stable(sdo)));

  assert_null_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);

  assert_second_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (edge_cnt == CNT_W'(2)));

  assert_word_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(word_q));

  assert_zero_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cnt == CNT_MAX) |-> (!sdo && sdo_oe));

endmodule

bind adc_serial_emu adc_serial_emu_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_lvl), .cs_fall(cs_fall),
  .clk_fall(dclk_fall), .word_q(word_q), .edge_cnt(edge_cnt),
  .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/adc_serial_emu_test.sv
module adc_serial_emu_test;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         dclk = 1'b0;
  logic [W-1:0] sample_word = '0;
  logic         sdo;
  logic         sdo_oe;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  adc_serial_emu uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk),
    .sample_word(sample_word), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always #4 clk = ~clk;

  task automatic check(string req, logic exp_oe, logic exp_d);
    tests++;
    if (sdo_oe !== exp_oe || sdo !== exp_d) begin
      fails++;
      $display("FAIL %s: oe/sdo actual %b/%b expected %b/%b", req, sdo_oe, sdo, exp_oe, exp_d);
    end
  endtask

  // Expected line states per data-clock falling edge, built from the requirements.
  task automatic build(logic [W-1:0] w, ref logic [1:0] q[$]);
    q = {};
    q.push_back(2'b00);                              // sampling edge
    q.push_back(2'b10);                              // null bit
    for (int i = W-1; i >= 0; i--) q.push_back({1'b1, w[i]});
    for (int i = 1; i < W; i++)    q.push_back({1'b1, w[i]});
  endtask

  function automatic string tag(int k, logic [W-1:0] w);
    if (k <= 2) return "R2";
    if (k <= W + 2) return (w == '0 || w == '1) ? "R9" : "R3";
    if (k <= 2*W + 1) return "R5";
    return "R6";
  endfunction

  task automatic frame(logic [W-1:0] w, int pulses, bit abort_frame);
    logic [1:0] q[$];
    logic [1:0] prev;
    build(w, q);
    sample_word = w;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R2", 1'b0, 1'b0);
    sample_word = ~w;                                // R7: must be ignored
    prev = 2'b00;
    for (int k = 1; k <= pulses; k++) begin
      logic [1:0] e;
      dclk = 1'b1;
      repeat (3) @(negedge clk);
      check("R4", prev[1], prev[0]);
      @(negedge clk);
      dclk = 1'b0;
      repeat (4) @(negedge clk);
      e = (k <= q.size()) ? q[k-1] : 2'b10;
      check((k > 2 && k <= W + 2) ? {tag(k, w), "/R7"} : tag(k, w), e[1], e[0]);
      prev = e;
    end
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check(abort_frame ? "R8" : "R1", 1'b0, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 1'b0, 1'b0);
    frame(12'hA5C, 30, 1'b0);
    frame(12'h000, 16, 1'b0);
    frame(12'hFFF, 16, 1'b0);
    frame(12'h3C7, 7, 1'b1);
    frame(12'h812, 40, 1'b0);   // R8 restart after abort, R6 long tail
    frame(12'h001, 27, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule